// File: doc/BRIEF.md
# Match-Compare Timer

This block is a memory-mapped event timer. A prescaler divides the clock, a 32-bit up-counter advances once per prescaled tick, and a single compare register is checked against the counter on every tick. When the two are equal, the block can take any combination of three actions: latch an interrupt flag, return the counter to zero, or switch counting off. Interrupt plus return-to-zero gives a periodic tick. Adding the switch-off action gives a one-shot event that stays quiet until software enables the timer again.

Software reaches seven word registers through a plain synchronous bus. Writes take effect at the clock edge on which `bus_we` is high. Reads are combinational from `bus_addr`. The interrupt output is a level and stays high until software clears the flag with a write-one.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Offsets are flag 0x000, control 0x004, counter 0x008, prescale 0x00C, action 0x014, compare 0x018 and source 0x070. Any other offset reads zero. Prescale and compare read back all 32 bits. Control reads back bits [1:0], action reads back bits [2:0] and source reads back bits [1:0].
- R3: Control bit 0 is run and bit 1 is hold. With run set, hold clear, source 0 and prescale 0, the counter rises by one on every clock edge after the edge that wrote run.
- R4: With prescale value P, the counter rises once every P+1 clock edges while counting.
- R5: While hold is set, the counter and the prescaler stay at zero whatever the run bit is. Counting resumes from zero once hold is cleared.
- R6: A match is a prescaled tick on which the counter equals the compare value. If action bit 0 is set, a match sets flag bit 0, and `irq_o` follows that bit.
- R7: Writing 1 to flag bit 0 clears it. Writing 0 leaves it unchanged.
- R8: If action bit 1 is set, a match loads zero into the counter instead of incrementing it. With compare value M, matches repeat every M+1 ticks.
- R9: If action bit 2 is set, a match clears control bit 0. The counter then stays at the match value, or at zero if action bit 1 is also set.
- R10: A counter value raises at most one match. When the timer is re-enabled while the counter still equals the compare value, no second match occurs and the counter moves on.
- R11: The counter can be written. With no action bits set it wraps from 0xFFFFFFFF to 0, and an equal compare value has no effect.
- R12: While the source register is nonzero, the counter does not advance. Only the value 0 (internal clock) counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Level interrupt, high while flag bit 0 is set |

## Verification
A write lands on the edge that samples it. With prescale 0, the counter reads n after n further edges. A match is taken on the edge after the tick that found the counter equal to the compare value, so the flag, `irq_o`, the reset-to-zero and the cleared run bit all appear together one edge after the counter shows M. The bench drives and samples on falling edges. It counts rising edges from the write that starts the timer, and reads each register just after a falling edge, so every expected value belongs to one known edge count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PRE   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_ACT   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_SRC   = 8'h70;

  localparam int CTL_RUN  = 0;
  localparam int CTL_HOLD = 1;
  localparam int CTL_W    = 2;
  localparam int SRC_W    = 2;

  // Action bits on a match: bit 2 halt, bit 1 clear, bit 0 interrupt
  typedef struct packed {
    logic halt;
    logic clr;
    logic irq;
  } act_t;

  localparam int ACT_W = $bits(act_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pre_q, pre_d;
  logic         pre_en;

  // >= keeps a lowered limit from forcing a full wrap of the divider
  assign tick   = run && !clr && (pre_q >= limit);
  assign pre_en = run || clr;

  always_comb begin
    pre_d = pre_q + 1'b1;
    if (clr || tick) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  input  logic         cmp_wr,
  input  logic         clr_on_hit,
  input  logic         halt_on_hit,
  output logic [W-1:0] count,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         seen_q, seen_d;

  assign hit   = tick && (cnt_q == cmp_val) && !seen_q;
  assign count = cnt_q;

  always_comb begin
    if (hold)                     cnt_d = '0;
    else if (load)                cnt_d = load_val;
    else if (hit && clr_on_hit)   cnt_d = '0;
    else if (hit && halt_on_hit)  cnt_d = cnt_q;
    else if (tick)                cnt_d = cnt_q + 1'b1;
    else                          cnt_d = cnt_q;
  end

  // Remember a match on the current value until the value moves
  always_comb begin
    if (hold || load || cmp_wr) seen_d = 1'b0;
    else if (cnt_d != cnt_q)    seen_d = 1'b0;
    else                        seen_d = seen_q || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              hit,
  input  logic [W-1:0]      count,
  output logic [CTL_W-1:0]  ctl,
  output act_t              act,
  output logic [W-1:0]      prescale,
  output logic [W-1:0]      cmp,
  output logic [SRC_W-1:0]  src,
  output logic              flag,
  output logic              cnt_load,
  output logic              cmp_wr
);
  logic             wr_flag, wr_ctl, wr_pre, wr_act, wr_src;
  logic             flag_d;
  logic [CTL_W-1:0] ctl_d;

  assign wr_flag  = bus_we && (bus_addr == OFS_FLAG);
  assign wr_ctl   = bus_we && (bus_addr == OFS_CTL);
  assign cnt_load = bus_we && (bus_addr == OFS_CNT);
  assign wr_pre   = bus_we && (bus_addr == OFS_PRE);
  assign wr_act   = bus_we && (bus_addr == OFS_ACT);
  assign cmp_wr   = bus_we && (bus_addr == OFS_CMP);
  assign wr_src   = bus_we && (bus_addr == OFS_SRC);

  // A new match wins over a simultaneous clear
  always_comb begin
    flag_d = flag;
    if (wr_flag && bus_wdata[0]) flag_d = 1'b0;
    if (hit && act.irq)          flag_d = 1'b1;
  end

  // A software write wins over the halt action
  always_comb begin
    ctl_d = ctl;
    if (hit && act.halt) ctl_d[CTL_RUN] = 1'b0;
    if (wr_ctl)          ctl_d = bus_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ctl  <= '0;
    end else begin
      flag <= flag_d;
      ctl  <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prescale <= '0;
    else if (wr_pre) prescale <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp <= '0;
    else if (cmp_wr) cmp <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act <= '0;
    else if (wr_act) act <= act_t'(bus_wdata[ACT_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src <= '0;
    else if (wr_src) src <= bus_wdata[SRC_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_FLAG: bus_rdata[0]          = flag;
      OFS_CTL:  bus_rdata[CTL_W-1:0]  = ctl;
      OFS_CNT:  bus_rdata             = count;
      OFS_PRE:  bus_rdata             = prescale;
      OFS_ACT:  bus_rdata[ACT_W-1:0]  = act;
      OFS_CMP:  bus_rdata             = cmp;
      OFS_SRC:  bus_rdata[SRC_W-1:0]  = src;
      default:  bus_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CTL_W-1:0]  ctl;
  act_t              act;
  logic [DATA_W-1:0] prescale, cmp, count;
  logic [SRC_W-1:0]  src;
  logic              flag, cnt_load, cmp_wr;
  logic              run, hold, tick, hit;

  assign hold  = ctl[CTL_HOLD];
  assign run   = ctl[CTL_RUN] && (src == '0);
  assign irq_o = flag;

  tmr_regs #(.W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .hit(hit), .count(count),
    .ctl(ctl), .act(act), .prescale(prescale), .cmp(cmp), .src(src),
    .flag(flag), .cnt_load(cnt_load), .cmp_wr(cmp_wr)
  );

  tmr_prescale #(.W(DATA_W)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .run(run), .clr(hold), .limit(prescale),
    .tick(tick)
  );

  tmr_count #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tick(tick), .hold(hold),
    .load(cnt_load), .load_val(bus_wdata),
    .cmp_val(cmp), .cmp_wr(cmp_wr),
    .clr_on_hit(act.clr), .halt_on_hit(act.halt),
    .count(count), .hit(hit)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              wd0,
  input logic              tick,
  input logic              hit,
  input logic              hold,
  input logic              run_bit,
  input logic              load,
  input act_t              act,
  input logic [W-1:0]      count,
  input logic              irq
);
  logic wr_flag1, wr_ctl;
  assign wr_flag1 = bus_we && (bus_addr == OFS_FLAG) && wd0;
  assign wr_ctl   = bus_we && (bus_addr == OFS_CTL);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit && !hold && !load) |=> (count == $past(count) + 1'b1));

  assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (count == '0));

  assert_match_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act.irq) |=> irq);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag1 && !(hit && act.irq)) |=> !irq);

  assert_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act.clr && !hold && !load) |=> (count == '0));

  assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act.halt && !wr_ctl) |=> !run_bit);

  assert_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !(hit && $stable(count)));
endmodule

bind match_timer match_timer_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .wd0(bus_wdata[0]), .tick(tick), .hit(hit), .hold(hold),
  .run_bit(ctl[0]), .load(cnt_load), .act(act), .count(count), .irq(irq_o)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  localparam logic [7:0] A_FLAG = 8'h00, A_CTL = 8'h04, A_CNT = 8'h08,
                         A_PRE = 8'h0C, A_ACT = 8'h14, A_CMP = 8'h18,
                         A_SRC = 8'h70;

  logic        clk, rst_n, bus_we, irq_o;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  match_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup_held();
    wr(A_CTL, 32'h2); wr(A_ACT, 0); wr(A_PRE, 0);
    wr(A_CMP, 0); wr(A_SRC, 0); wr(A_FLAG, 1);
  endtask

  task automatic t_reset();
    rd_chk("R1 flag", A_FLAG, 0); rd_chk("R1 ctl", A_CTL, 0);
    rd_chk("R1 cnt", A_CNT, 0);   rd_chk("R1 pre", A_PRE, 0);
    rd_chk("R1 act", A_ACT, 0);   rd_chk("R1 cmp", A_CMP, 0);
    rd_chk("R1 src", A_SRC, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_readback();
    wr(A_PRE, 32'hA5A5_1234); wr(A_CMP, 32'hDEAD_BEEF);
    wr(A_ACT, 32'hFF); wr(A_SRC, 32'hFF); wr(A_CTL, 32'hFF);
    rd_chk("R2 pre", A_PRE, 32'hA5A5_1234);
    rd_chk("R2 cmp", A_CMP, 32'hDEAD_BEEF);
    rd_chk("R2 act", A_ACT, 32'h7);
    rd_chk("R2 src", A_SRC, 32'h3);
    rd_chk("R2 ctl", A_CTL, 32'h3);
    rd_chk("R2 unmapped", 8'h10, 0);
  endtask

  task automatic t_free();
    setup_held();
    wr(A_CTL, 1);
    rd_chk("R3 start", A_CNT, 0);
    idle(5);
    rd_chk("R3 five edges", A_CNT, 5);
  endtask

  task automatic t_prescale();
    setup_held();
    wr(A_PRE, 3);
    wr(A_CTL, 1);
    idle(8);  rd_chk("R4 eight edges", A_CNT, 2);
    idle(3);  rd_chk("R4 eleven edges", A_CNT, 2);
    idle(1);  rd_chk("R4 twelve edges", A_CNT, 3);
  endtask

  task automatic t_hold();
    setup_held();
    wr(A_CTL, 1);
    idle(3);
    wr(A_CTL, 3);
    idle(1);  rd_chk("R5 held", A_CNT, 0);
    idle(4);  rd_chk("R5 still held", A_CNT, 0);
    wr(A_CTL, 1);
    idle(2);  rd_chk("R5 resume", A_CNT, 2);
  endtask

  task automatic t_periodic();
    setup_held();
    wr(A_CMP, 4); wr(A_ACT, 3);
    wr(A_CTL, 1);
    idle(4);
    rd_chk("R8 at compare", A_CNT, 4);
    rd_chk("R6 no flag yet", A_FLAG, 0);
    idle(1);
    rd_chk("R8 cleared", A_CNT, 0);
    rd_chk("R6 flag set", A_FLAG, 1);
    check("R6 irq high", {31'b0, irq_o}, 1);
    wr(A_FLAG, 1);
    rd_chk("R7 cleared", A_FLAG, 0);
    rd_chk("R8 count after clear", A_CNT, 2);
    idle(2);
    rd_chk("R8 second pass", A_CNT, 4);
    idle(1);
    rd_chk("R8 period", A_FLAG, 1);
    rd_chk("R8 wrap zero", A_CNT, 0);
  endtask

  task automatic t_oneshot();
    setup_held();
    wr(A_CMP, 3); wr(A_ACT, 7);
    wr(A_CTL, 1);
    idle(3);  rd_chk("R9 before", A_CNT, 3);
    idle(1);
    rd_chk("R9 zeroed", A_CNT, 0);
    rd_chk("R9 run cleared", A_CTL, 0);
    rd_chk("R6 one-shot flag", A_FLAG, 1);
    idle(3);  rd_chk("R9 stays stopped", A_CNT, 0);
    wr(A_FLAG, 0);
    rd_chk("R7 write zero", A_FLAG, 1);
    wr(A_FLAG, 1);
    rd_chk("R7 write one", A_FLAG, 0);
    check("R7 irq low", {31'b0, irq_o}, 0);
  endtask

  task automatic t_once();
    setup_held();
    wr(A_CMP, 2); wr(A_ACT, 5);
    wr(A_CTL, 1);
    idle(3);
    rd_chk("R9 halted at match", A_CNT, 2);
    rd_chk("R9 run off", A_CTL, 0);
    idle(3);  rd_chk("R9 frozen", A_CNT, 2);
    wr(A_FLAG, 1);
    wr(A_CTL, 1);
    idle(1);
    rd_chk("R10 moves on", A_CNT, 3);
    rd_chk("R10 no retrigger", A_FLAG, 0);
    rd_chk("R10 still running", A_CTL, 1);
  endtask

  task automatic t_wrap();
    setup_held();
    wr(A_CTL, 0);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_CTL, 1);
    rd_chk("R11 loaded", A_CNT, 32'hFFFF_FFFE);
    idle(1);  rd_chk("R11 top", A_CNT, 32'hFFFF_FFFF);
    idle(1);  rd_chk("R11 wrapped", A_CNT, 0);
    idle(2);
    rd_chk("R11 past zero", A_CNT, 2);
    rd_chk("R11 no action", A_FLAG, 0);
  endtask

  task automatic t_source();
    setup_held();
    wr(A_SRC, 1);
    wr(A_CTL, 1);
    idle(4);
    rd_chk("R12 no count", A_CNT, 0);
    rd_chk("R12 src value", A_SRC, 1);
    wr(A_SRC, 0);
    rd_chk("R12 switch", A_CNT, 0);
    idle(3);
    rd_chk("R12 internal clock", A_CNT, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_free();
    t_prescale();
    t_hold();
    t_periodic();
    t_oneshot();
    t_once();
    t_wrap();
    t_source();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule